// File: doc/BRIEF.md
# Endpoint Buffer Command Port

This block gives a microcontroller access to a device controller's endpoint packet buffers through a single 16-bit port. A select line marks each write cycle as either a command or a data cycle. A command byte chooses one of sixteen endpoint slots and an operation. The operation is a buffer write, a buffer read, a status read, or a stall change. The data words that follow move a length word and then packed payload bytes into or out of an internal buffer RAM.

Each endpoint keeps a pending-interrupt flag, which a transaction-complete pulse from the bus-engine side sets. Reading the endpoint's status clears the flag. Each endpoint also keeps a stall flag. A setup pulse or a stall command sets it, and an unstall command clears it. Endpoints chosen by a parameter mask have two buffer banks. When the word pointer runs off the end of one bank, it moves to the other bank. The block checks neither bounds nor direction.

Top module: `ep_cmd_port`

## Requirements
- R1: A write with `sel_cmd` high is a command. Only `din[7:0]` is decoded and `din[15:8]` has no effect.
- R2: Command codes select the operation and the endpoint index `code[3:0]`. Codes 01h–0Fh are buffer writes. Codes 10h and 12h–1Fh are buffer reads. Codes 50h–5Fh are status reads. Code 11h and any unlisted code leave the port idle.
- R3: In a buffer transfer, data word 0 is the 16-bit length N. Data word k (k ≥ 1) holds payload byte 2k−1 in bits 7:0 and byte 2k in bits 15:8.
- R4: When N is odd, the data word holding byte N has its high byte stored as zero and read back as zero.
- R5: Every command resets the word pointer to the length word and aborts any unfinished transfer.
- R6: A single-buffered endpoint has 1+⌈SLOT_BYTES/2⌉ words. Access past the last word wraps silently to word 0 of the same slot.
- R7: On an endpoint in `DBL_MASK`, access past the last word switches to word 0 of the other bank. The bank choice persists for later commands and is reported in status bit 2.
- R8: A `done_stb` pulse sets `irq_flags[done_ep]`, and the bit stays set until a status read of that endpoint.
- R9: After a status command, the next data read returns {13'b0, bank, irq, stall} and clears that endpoint's irq bit. A simultaneous `done_stb` for the same endpoint wins.
- R10: A `setup_stb` pulse or a command 40h–4Fh sets the endpoint's stall bit (status bit 0). A command 70h–7Fh clears it.
- R11: After reset, all irq, stall and bank bits are zero and `dout` reads zero while the port is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_cmd | input | 1 | High: command cycle; low: data cycle |
| wr_stb | input | 1 | Write strobe, one per cycle |
| rd_stb | input | 1 | Read strobe; pointer advances at the edge |
| din | input | 16 | Write data / command byte |
| dout | output | 16 | Read data for the current pointer or status |
| done_stb | input | 1 | Bus-engine transaction complete |
| done_ep | input | 4 | Endpoint index for `done_stb` |
| setup_stb | input | 1 | Setup token received |
| setup_ep | input | 4 | Endpoint index for `setup_stb` |
| irq_flags | output | 16 | Per-endpoint pending interrupt bits |

## Verification
Some rules are checked by assertions on every cycle:
- Every command cycle resets the pointer.
- The pointer never leaves its slot.
- An interrupt bit rises only after a completion pulse.
- A status read clears its bit unless a completion for the same endpoint collides with it.
- The idle port drives zero.

Payload packing, odd-length masking, wraparound and bank switchover show up only in data values. The bench sweeps every length from 0 to 32 bytes and compares each read word against arithmetic expectations.

// File: rtl/ep_cmd_port.sv
module ep_cmd_port #(
  parameter int SLOT_BYTES = 32,
  parameter logic [15:0] DBL_MASK = 16'h0004
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_cmd,
  input  logic        wr_stb,
  input  logic        rd_stb,
  input  logic [15:0] din,
  output logic [15:0] dout,
  input  logic        done_stb,
  input  logic [3:0]  done_ep,
  input  logic        setup_stb,
  input  logic [3:0]  setup_ep,
  output logic [15:0] irq_flags
);
  localparam int SLOT_W = 1 + (SLOT_BYTES + 1) / 2;
  localparam int PW     = $clog2(SLOT_W);
  localparam int DEPTH  = 32 * (1 << PW);
  localparam logic [1:0] M_IDLE = 2'd0, M_WR = 2'd1, M_RD = 2'd2, M_ST = 2'd3;

  logic [15:0] mem [DEPTH];
  logic [1:0]  mode;
  logic [3:0]  ep;
  logic [PW-1:0] ptr;
  logic [15:0] len_r, stall, bank;

  wire [7:0] code   = din[7:0];
  wire       cmd_wr = sel_cmd && wr_stb;
  wire       d_wr   = !sel_cmd && wr_stb && mode == M_WR;
  wire       d_rd   = !sel_cmd && rd_stb && mode == M_RD;
  wire       st_rd  = !sel_cmd && rd_stb && mode == M_ST;
  wire       acc    = d_wr || d_rd;
  wire [PW+4:0] addr = {ep, bank[ep], ptr};
  wire [15:0] ptr2  = 16'({ptr, 1'b0});
  wire       odd_last = ptr != '0 && len_r == ptr2 - 16'd1;
  wire [15:0] raw   = mem[addr];
  wire [15:0] wdata = odd_last ? {8'h00, din[7:0]} : din;
  wire       at_end = ptr == PW'(SLOT_W - 1);

  always_comb begin
    case (mode)
      M_RD:    dout = odd_last ? {8'h00, raw[7:0]} : raw;
      M_ST:    dout = {13'b0, bank[ep], irq_flags[ep], stall[ep]};
      default: dout = '0;
    endcase
  end

  always_ff @(posedge clk) if (d_wr) mem[addr] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_IDLE; ep <= '0; ptr <= '0; len_r <= '0;
      stall <= '0; bank <= '0; irq_flags <= '0;
    end else begin
      if (cmd_wr) begin
        ep  <= code[3:0];
        ptr <= '0;
        case (code[7:4])
          4'h0:    mode <= (code[3:0] != 4'h0) ? M_WR : M_IDLE;
          4'h1:    mode <= (code[3:0] != 4'h1) ? M_RD : M_IDLE;
          4'h5:    mode <= M_ST;
          default: mode <= M_IDLE;
        endcase
        if (code[7:4] == 4'h4) stall[code[3:0]] <= 1'b1;
        if (code[7:4] == 4'h7) stall[code[3:0]] <= 1'b0;
      end else if (acc) begin
        if (ptr == '0) len_r <= d_wr ? din : raw;
        if (at_end) begin
          ptr <= '0;
          if (DBL_MASK[ep]) bank[ep] <= ~bank[ep];
        end else begin
          ptr <= ptr + 1'b1;
        end
      end else if (st_rd) begin
        mode <= M_IDLE;
      end
      if (setup_stb) stall[setup_ep] <= 1'b1;
      begin
        logic [15:0] nx;
        nx = irq_flags;
        if (st_rd) nx[ep] = 1'b0;
        if (done_stb) nx[done_ep] = 1'b1;
        irq_flags <= nx;
      end
    end
  end
endmodule

module ep_cmd_port_chk #(parameter int SLOT_W = 17, parameter int PW = 5) (
  input logic clk, rst_n, sel_cmd, wr_stb, rd_stb, done_stb,
  input logic [3:0] done_ep, ep,
  input logic [1:0] mode,
  input logic [PW-1:0] ptr,
  input logic [15:0] dout, irq_flags
);
  a_r5_cmd_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cmd && wr_stb) |=> ptr == '0);
  a_r6_ptr_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < SLOT_W);
  a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_flags & ~$past(irq_flags)) != 16'h0) |-> $past(done_stb));
  a_r9_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_cmd && rd_stb && mode == 2'd3 && !(done_stb && done_ep == ep))
    |=> !irq_flags[$past(ep)]);
  a_r9_status_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd3 |-> dout[15:3] == 13'h0);
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 |-> dout == 16'h0);
endmodule

bind ep_cmd_port ep_cmd_port_chk #(.SLOT_W(SLOT_W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_cmd(sel_cmd), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .done_stb(done_stb), .done_ep(done_ep), .ep(ep), .mode(mode), .ptr(ptr),
  .dout(dout), .irq_flags(irq_flags));

// File: tb/test_ep_cmd_port.sv
module test_ep_cmd_port;
  localparam int SLOT_W = 17;
  logic clk = 0, rst_n = 0, sel_cmd = 0, wr_stb = 0, rd_stb = 0;
  logic [15:0] din = 0;
  logic done_stb = 0, setup_stb = 0;
  logic [3:0] done_ep = 0, setup_ep = 0;
  logic [15:0] dout, irq_flags;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ep_cmd_port i_ep_cmd_port (.clk(clk), .rst_n(rst_n), .sel_cmd(sel_cmd),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din), .dout(dout),
    .done_stb(done_stb), .done_ep(done_ep), .setup_stb(setup_stb),
    .setup_ep(setup_ep), .irq_flags(irq_flags));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cmd(logic [15:0] c);
    @(negedge clk); sel_cmd = 1; wr_stb = 1; din = c;
    @(negedge clk); wr_stb = 0; sel_cmd = 0;
  endtask

  task automatic wdat(logic [15:0] d);
    @(negedge clk); sel_cmd = 0; wr_stb = 1; din = d;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rdat(output logic [15:0] v);
    @(negedge clk); sel_cmd = 0; rd_stb = 1; #1 v = dout;
    @(negedge clk); rd_stb = 0;
  endtask

  function automatic logic [7:0] pb(int b, int seed);
    return 8'((b * 37 + seed) & 255);
  endfunction

  function automatic logic [15:0] pw(int k, int n, int seed);
    logic [7:0] hi;
    hi = (2 * k > n) ? 8'h00 : pb(2 * k, seed);
    return {hi, pb(2 * k - 1, seed)};
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R11 irq reset", irq_flags, 16'h0);
    chk("R11 idle dout", dout, 16'h0);
    cmd(16'h0055); rdat(v);
    chk("R11 status reset", v, 16'h0);

    // R3 / R4 sweep over every payload length on endpoint 3
    for (int n = 0; n <= 32; n++) begin
      cmd(16'h0003);
      wdat(16'(n));
      for (int k = 1; k <= (n + 1) / 2; k++)
        wdat({pb(2 * k, n), pb(2 * k - 1, n)});
      cmd(16'h0013);
      rdat(v); chk("R3 length word", v, 16'(n));
      for (int k = 1; k <= (n + 1) / 2; k++) begin
        rdat(v);
        chk((n % 2 == 1 && 2 * k - 1 == n) ? "R4 odd last" : "R3 packing", v, pw(k, n, n));
      end
    end

    // R1 upper command byte ignored; R2 code 11h idle
    cmd(16'hAB03); wdat(16'd2); wdat(16'h5A5A);
    cmd(16'hCD13); rdat(v); chk("R1 high byte ignored", v, 16'd2);
    rdat(v); chk("R1 data", v, 16'h5A5A);
    cmd(16'h0011); rdat(v); chk("R2 code 11h idle", v, 16'h0);
    cmd(16'h0033); rdat(v); chk("R2 unlisted code idle", v, 16'h0);

    // R5 abort mid-transfer
    cmd(16'h0004); wdat(16'd6); wdat(16'h1111);
    cmd(16'h0004); wdat(16'd4); wdat(16'h2222);
    cmd(16'h0014); rdat(v); chk("R5 rewind length", v, 16'd4);
    rdat(v); chk("R5 rewind data", v, 16'h2222);

    // R6 single buffer wraps within slot
    cmd(16'h0006); wdat(16'd32);
    for (int k = 1; k < SLOT_W; k++) wdat(16'(k * 257));
    wdat(16'hBEEF);
    cmd(16'h0016); rdat(v); chk("R6 wrap onto length", v, 16'hBEEF);
    rdat(v); chk("R6 word1 kept", v, 16'd257);
    cmd(16'h0056); rdat(v); chk("R6 no bank change", v, 16'h0);

    // R7 double-buffered endpoint 2 switches bank
    cmd(16'h0002); wdat(16'd32);
    for (int k = 1; k < SLOT_W; k++) wdat(16'(k + 100));
    wdat(16'd2); wdat(16'hC0DE);
    cmd(16'h0052); rdat(v); chk("R7 bank status", v, 16'h4);
    cmd(16'h0012); rdat(v); chk("R7 secondary length", v, 16'd2);
    rdat(v); chk("R7 secondary data", v, 16'hC0DE);

    // R8 / R9 interrupt flags
    @(negedge clk); done_stb = 1; done_ep = 4'd5;
    @(negedge clk); done_stb = 0;
    repeat (3) @(negedge clk);
    chk("R8 irq held", irq_flags, 16'h0020);
    cmd(16'h0055); rdat(v); chk("R9 status irq", v, 16'h2);
    @(negedge clk); chk("R9 irq cleared", irq_flags, 16'h0);
    @(negedge clk); done_stb = 1; done_ep = 4'd9;
    @(negedge clk); done_stb = 0;
    cmd(16'h0059);
    @(negedge clk); rd_stb = 1; done_stb = 1; done_ep = 4'd9; #1 v = dout;
    @(negedge clk); rd_stb = 0; done_stb = 0;
    chk("R9 status pre-collision", v, 16'h2);
    chk("R9 set wins", irq_flags, 16'h0200);
    cmd(16'h0059); rdat(v);
    @(negedge clk); chk("R9 final clear", irq_flags, 16'h0);

    // R10 stall control
    @(negedge clk); setup_stb = 1; setup_ep = 4'd7;
    @(negedge clk); setup_stb = 0;
    cmd(16'h0057); rdat(v); chk("R10 setup stall", v, 16'h1);
    cmd(16'h0077); cmd(16'h0057); rdat(v); chk("R10 unstall", v, 16'h0);
    cmd(16'h0047); cmd(16'h0057); rdat(v); chk("R10 stall cmd", v, 16'h1);

    finished = 1;
    summary();
  end
endmodule